// File: doc/BRIEF.md
# Video Field and Frame Capture Sequencer

This block decides which incoming video fields are captured and when each capture ends. It follows the raster using field-start, line-start and pixel strobes. It compares the current pixel column and line against programmed stop coordinates. While a capture is under way it drives a gate that tells the data path which pixel strobes to keep.

At each stop point it records completion status for field 1, field 2 or a whole frame. Any completion also raises a summary flag and, when enabled, an interrupt. Software acknowledges completion by pulsing clear strobes.

Three capture policies are available. Continuous capture restarts at every selected field or frame. Non-continuous capture stops once the processor lets a second completion arrive without clearing the first. Single-frame capture waits until the processor clears the status. Sync-code extraction and the pixel data path sit outside this block.

Top module: `cap_seq_top`

## Requirements
- R1: Capture starts only at the first field start that carries field id 0 (a frame start) after `cap_en` is high. Until then no gate is produced. While `cap_en` is low, `cap_gate` stays low and the wait for a frame start begins again.
- R2: Position rules: a field start sets column and line to 0, a line start adds one to the line and sets the column to 0, and each pixel advances the column. In a captured field, `cap_gate` is high one cycle after every pixel strobe, from the first pixel through the pixel at (`xstop`, `ystop`) inclusive, and never after it.
- R3: `cmp_stat` bit 0 is field 1 done, bit 1 is field 2 done and bit 2 is frame done. Each bit sets in the cycle after the final strobe of the stop pixel. It holds until its `clr_stat` bit is pulsed, and a set in the same cycle as a clear wins.
- R4: `cmp_flag` sets on any completion and clears on `clr_cmp`. `cmp_irq` equals `cmp_flag` AND `irq_en`, with the same one-cycle timing.
- R5: With `cap_mode` = 0 (continuous), every selected field or frame is captured, whether or not its status is cleared.
- R6: With `cap_mode` = 1 (non-continuous), a capture completing while its status bit is still set blocks further captures of that target. Capture resumes at the next matching start once software clears that bit.
- R7: With `cap_mode` = 2 or 3 (single), a field or frame whose status bit is set is not captured.
- R8: With `frame_mode` = 1, a capture granted at a frame start covers field 1 and the following field 2. Reaching the stop point in field 1 ends that field's gate without status. Reaching it in field 2 sets the frame bit.
- R9: `fmt` = 4 (separate luma/chroma) takes one strobe per pixel. `fmt` = 0 (embedded-sync 8-bit) takes two strobes per pixel, and both are gated. Any other `fmt` value disables capture.
- R10: With `frame_mode` = 0, only fields whose select bit is set (`sel_f1` for id 0, `sel_f2` for id 1) are captured.
- R11: If the stop point lies outside the field, the gate covers every pixel of the field and no status is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable |
| cap_mode | input | 2 | 0 continuous, 1 non-continuous, 2/3 single |
| frame_mode | input | 1 | 1: capture whole frames, 0: single fields |
| sel_f1 | input | 1 | Capture field 1 in field mode |
| sel_f2 | input | 1 | Capture field 2 in field mode |
| fmt | input | 3 | Input format code (0 embedded 8-bit, 4 separate luma/chroma) |
| fld_start | input | 1 | Field start strobe |
| fld_id | input | 1 | Identity of the starting field (0 = field 1) |
| line_start | input | 1 | Start of a new line after the first |
| pix_stb | input | 1 | Pixel sample strobe |
| xstop | input | PW | Stop column |
| ystop | input | PW | Stop line |
| clr_stat | input | 3 | Clear strobes for the status bits |
| clr_cmp | input | 1 | Clear strobe for the summary flag |
| irq_en | input | 1 | Interrupt enable |
| cap_gate | output | 1 | Registered capture-active gate |
| cmp_stat | output | 3 | Completion status bits |
| cmp_flag | output | 1 | Any-completion flag |
| cmp_irq | output | 1 | Capture-complete interrupt |

## Verification
Fields are driven with four stop points: a mid-field point, the very first pixel, the last pixel, and a column beyond the line. Comparing gate counts for these cases shows whether the window is inclusive and whether it wraps across lines. Field sequences are run with status left set and with status cleared between fields, in all three modes. These runs show whether the blocking decision follows each mode's handshake rule. Fields arriving before a frame start, unselected fields, and the two format codes plus an invalid one show the arming, selection and strobes-per-pixel rules.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
  typedef enum logic [1:0] {
    CM_CONT    = 2'd0,
    CM_NONCONT = 2'd1,
    CM_SINGLE  = 2'd2,
    CM_SINGLE2 = 2'd3
  } cap_mode_e;

  localparam int TGT_F1  = 0;
  localparam int TGT_F2  = 1;
  localparam int TGT_FRM = 2;
  localparam int NTGT    = 3;

  localparam logic [2:0] FMT_EMB = 3'd0;
  localparam logic [2:0] FMT_YC  = 3'd4;
endpackage

// File: rtl/cap_pos_trk.sv
module cap_pos_trk #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fld_start,
  input  logic          line_start,
  input  logic          pix_stb,
  input  logic          two_per_pix,
  input  logic [PW-1:0] xstop,
  input  logic [PW-1:0] ystop,
  output logic          at_stop
);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [PW-1:0] xpos, ypos;
  logic          phase;

  always_ff @(posedge clk) begin
    if (rst || fld_start) begin
      xpos  <= '0;
      ypos  <= '0;
      phase <= 1'b0;
    end else if (line_start) begin
      xpos  <= '0;
      phase <= 1'b0;
      if (ypos != PMAX) ypos <= ypos + 1'b1;
    end else if (pix_stb) begin
      if (two_per_pix && !phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (xpos != PMAX) xpos <= xpos + 1'b1;
      end
    end
  end

  // last strobe of the pixel sitting on the stop coordinate
  assign at_stop = pix_stb && (xpos == xstop) && (ypos == ystop) &&
                   (!two_per_pix || phase);
endmodule

// File: rtl/cap_fld_ctl.sv
module cap_fld_ctl
  import cap_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            fld_start,
  input  logic            fld_id,
  input  logic            frame_mode,
  input  logic [1:0]      sel,
  input  logic [NTGT-1:0] permit,
  input  logic            pix_stb,
  input  logic            at_stop,
  output logic            take,
  output logic [NTGT-1:0] done
);
  logic armed, active, cur_f2, frm_go;
  logic arm_now, start;

  always_comb begin
    arm_now = armed | ~fld_id;
    if (frame_mode) begin
      start = fld_id ? frm_go : permit[TGT_FRM];
    end else begin
      start = arm_now && sel[fld_id] && permit[fld_id ? TGT_F2 : TGT_F1];
    end
  end

  assign take = active & pix_stb;

  always_comb begin
    done = '0;
    if (take && at_stop) begin
      if (frame_mode) done[TGT_FRM] = cur_f2;
      else if (cur_f2) done[TGT_F2] = 1'b1;
      else done[TGT_F1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      armed  <= 1'b0;
      active <= 1'b0;
      cur_f2 <= 1'b0;
      frm_go <= 1'b0;
    end else if (fld_start) begin
      armed  <= arm_now;
      active <= start;
      cur_f2 <= fld_id;
      frm_go <= frame_mode & ~fld_id & start;
    end else if (take && at_stop) begin
      active <= 1'b0;
    end
  end

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done)); // R3
  AST_DONE_IN_FIELD: assert property (@(posedge clk) disable iff (rst)
    (|done) |-> (pix_stb && run)); // R2
endmodule

// File: rtl/cap_stat.sv
module cap_stat
  import cap_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  cap_mode_e       mode,
  input  logic [NTGT-1:0] done,
  input  logic [NTGT-1:0] clr,
  input  logic            clr_cmp,
  input  logic            irq_en,
  output logic [NTGT-1:0] stat,
  output logic [NTGT-1:0] permit,
  output logic            cmp_flag,
  output logic            irq
);
  logic [NTGT-1:0] stale;
  logic            cmp_nxt;

  for (genvar k = 0; k < NTGT; k++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) stat[k] <= 1'b0;
      else if (done[k]) stat[k] <= 1'b1;
      else if (clr[k]) stat[k] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst || !run) stale[k] <= 1'b0;
      else if (done[k] && stat[k] && mode == CM_NONCONT) stale[k] <= 1'b1;
      else if (clr[k] && !done[k]) stale[k] <= 1'b0;
    end

    always_comb begin
      unique case (mode)
        CM_CONT:    permit[k] = 1'b1;
        CM_NONCONT: permit[k] = ~stale[k];
        default:    permit[k] = ~stat[k];
      endcase
    end

    AST_STAT_SRC: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[k]) |-> $past(done[k])); // R3
  end

  assign cmp_nxt = (|done) | (cmp_flag & ~clr_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      cmp_flag <= cmp_nxt;
      irq      <= irq_en & cmp_nxt;
    end
  end

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en)); // R4
endmodule

// File: rtl/cap_seq_top.sv
module cap_seq_top
  import cap_seq_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [1:0]    cap_mode,
  input  logic          frame_mode,
  input  logic          sel_f1,
  input  logic          sel_f2,
  input  logic [2:0]    fmt,
  input  logic          fld_start,
  input  logic          fld_id,
  input  logic          line_start,
  input  logic          pix_stb,
  input  logic [PW-1:0] xstop,
  input  logic [PW-1:0] ystop,
  input  logic [2:0]    clr_stat,
  input  logic          clr_cmp,
  input  logic          irq_en,
  output logic          cap_gate,
  output logic [2:0]    cmp_stat,
  output logic          cmp_flag,
  output logic          cmp_irq
);
  logic            fmt_ok, two_pp, run, at_stop, take;
  logic [NTGT-1:0] done, permit;

  assign fmt_ok = (fmt == FMT_EMB) || (fmt == FMT_YC);
  assign two_pp = (fmt == FMT_EMB);
  assign run    = cap_en & fmt_ok;

  cap_pos_trk #(.PW(PW)) u_pos (
    .clk(clk), .rst(rst), .fld_start(fld_start), .line_start(line_start),
    .pix_stb(pix_stb), .two_per_pix(two_pp), .xstop(xstop), .ystop(ystop),
    .at_stop(at_stop)
  );

  cap_fld_ctl u_ctl (
    .clk(clk), .rst(rst), .run(run), .fld_start(fld_start), .fld_id(fld_id),
    .frame_mode(frame_mode), .sel({sel_f2, sel_f1}), .permit(permit),
    .pix_stb(pix_stb), .at_stop(at_stop), .take(take), .done(done)
  );

  cap_stat u_stat (
    .clk(clk), .rst(rst), .run(run), .mode(cap_mode_e'(cap_mode)),
    .done(done), .clr(clr_stat), .clr_cmp(clr_cmp), .irq_en(irq_en),
    .stat(cmp_stat), .permit(permit), .cmp_flag(cmp_flag), .irq(cmp_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) cap_gate <= 1'b0;
    else     cap_gate <= take;
  end

  AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    cap_gate |-> $past(cap_en)); // R1
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    cap_mode[1] |-> ((done & cmp_stat) == 3'b000)); // R7
endmodule

// File: tb/sim_cap_seq_top.sv
module sim_cap_seq_top;
  localparam int PW  = 12;
  localparam int PPL = 6;
  localparam int NL  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cap_en = 1'b0;
  logic [1:0]    cap_mode = 2'd0;
  logic          frame_mode = 1'b0;
  logic          sel_f1 = 1'b0, sel_f2 = 1'b0;
  logic [2:0]    fmt = 3'd4;
  logic          fld_start = 1'b0, fld_id = 1'b0;
  logic          line_start = 1'b0, pix_stb = 1'b0;
  logic [PW-1:0] xstop = 12'd3, ystop = 12'd2;
  logic [2:0]    clr_stat = 3'b000;
  logic          clr_cmp = 1'b0, irq_en = 1'b0;
  logic          cap_gate, cmp_flag, cmp_irq;
  logic [2:0]    cmp_stat;

  always #5 clk = ~clk;

  cap_seq_top #(.PW(PW)) u0 (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_mode(cap_mode),
    .frame_mode(frame_mode), .sel_f1(sel_f1), .sel_f2(sel_f2), .fmt(fmt),
    .fld_start(fld_start), .fld_id(fld_id), .line_start(line_start),
    .pix_stb(pix_stb), .xstop(xstop), .ystop(ystop), .clr_stat(clr_stat),
    .clr_cmp(clr_cmp), .irq_en(irq_en), .cap_gate(cap_gate),
    .cmp_stat(cmp_stat), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  typedef struct {
    int    gates;
    int    stat;
    int    cmp;
    int    irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0, gate_cnt = 0;
  bit   finished = 1'b0;

  // reference model state
  bit       m_armed, m_frmgo, m_cmp;
  bit [2:0] m_stat, m_stale;

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: counts gate cycles and compares against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (cap_gate) gate_cnt++;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "gate count", gate_cnt, e.gates);
        chk(e.tag, "status", int'(cmp_stat), e.stat);
        chk(e.tag, "cmp flag", int'(cmp_flag), e.cmp);
        chk(e.tag, "irq", int'(cmp_irq), e.irq);
        gate_cnt = 0;
      end
    end
  end

  task automatic push(string tag, int gates);
    exp_t e;
    e.gates = gates;
    e.stat  = int'(m_stat);
    e.cmp   = int'(m_cmp);
    e.irq   = int'(m_cmp && irq_en);
    e.tag   = tag;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  function automatic bit permit(int k);
    if (cap_mode == 2'd0) return 1'b1;
    if (cap_mode == 2'd1) return !m_stale[k];
    return !m_stat[k];
  endfunction

  task automatic field(bit fid, string tag);
    bit run, cap, arm_now, stop_in;
    int spp, gates, tgt;
    run     = cap_en && (fmt == 3'd0 || fmt == 3'd4);
    spp     = (fmt == 3'd0) ? 2 : 1;
    stop_in = (int'(ystop) < NL) && (int'(xstop) < PPL);
    cap = 1'b0;
    tgt = -1;
    if (!run) begin
      m_armed = 0; m_frmgo = 0; m_stale = 0;
    end else begin
      arm_now = m_armed || !fid;
      m_armed = arm_now;
      if (frame_mode) begin
        if (!fid) begin cap = permit(2); m_frmgo = cap; end
        else begin cap = m_frmgo; m_frmgo = 0; end
        if (fid) tgt = 2;
      end else begin
        cap = arm_now && (fid ? sel_f2 : sel_f1) && permit(fid ? 1 : 0);
        tgt = fid ? 1 : 0;
        m_frmgo = 0;
      end
    end
    gates = 0;
    if (cap) gates = stop_in ? (int'(ystop) * PPL + int'(xstop) + 1) * spp
                             : NL * PPL * spp;
    if (cap && stop_in && tgt >= 0) begin
      if (cap_mode == 2'd1 && m_stat[tgt]) m_stale[tgt] = 1'b1;
      m_stat[tgt] = 1'b1;
      m_cmp = 1'b1;
    end
    // drive the field
    fld_start = 1'b1; fld_id = fid;
    @(posedge clk); #1; fld_start = 1'b0;
    for (int ln = 0; ln < NL; ln++) begin
      if (ln > 0) begin
        line_start = 1'b1; @(posedge clk); #1; line_start = 1'b0;
      end
      for (int s = 0; s < PPL * spp; s++) begin
        pix_stb = 1'b1; @(posedge clk); #1; pix_stb = 1'b0;
        if (s % 3 == 2) begin @(posedge clk); #1; end
      end
    end
    repeat (3) @(posedge clk);
    #1;
    push(tag, gates);
  endtask

  task automatic clr(bit [2:0] sm, bit cm, string tag);
    clr_stat = sm; clr_cmp = cm;
    @(posedge clk); #1;
    clr_stat = 3'b000; clr_cmp = 1'b0;
    for (int k = 0; k < 3; k++) if (sm[k]) begin m_stat[k] = 0; m_stale[k] = 0; end
    if (cm) m_cmp = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    push(tag, 0);
  endtask

  task automatic en_off();
    cap_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_armed = 0; m_frmgo = 0; m_stale = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_armed = 0; m_frmgo = 0; m_cmp = 0; m_stat = 0; m_stale = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    push("R3 reset", 0);

    // continuous, field mode, field 1 selected, separate luma/chroma
    irq_en = 1; sel_f1 = 1; cap_mode = 2'd0; cap_en = 1;
    field(1, "R1 before frame start");
    field(0, "R2 first capture");
    field(1, "R10 unselected field");
    field(0, "R5 continuous repeat");
    clr(3'b001, 1'b1, "R4 clear drops irq");
    irq_en = 0;
    field(1, "R10 unselected field");
    field(0, "R4 masked irq");
    sel_f1 = 0; sel_f2 = 1;
    field(0, "R10 f1 not selected");
    field(1, "R10 f2 selected");
    en_off();
    field(0, "R1 disabled");
    clr(3'b111, 1'b1, "R3 clear all");

    // stop point corners
    sel_f1 = 1; sel_f2 = 0; cap_en = 1;
    xstop = 0; ystop = 0;
    field(0, "R2 first pixel stop");
    xstop = PPL - 1; ystop = NL - 1;
    field(0, "R2 last pixel stop");
    xstop = PPL + 1; ystop = 1;
    clr(3'b001, 1'b0, "R3 clear f1");
    field(0, "R11 stop outside field");
    xstop = 3; ystop = 2;

    // non-continuous
    en_off();
    clr(3'b111, 1'b1, "R3 clear all");
    cap_mode = 2'd1; irq_en = 1; cap_en = 1;
    field(0, "R6 first");
    field(1, "R6 gap");
    field(0, "R6 second while set");
    field(0, "R6 blocked");
    clr(3'b001, 1'b0, "R6 clear");
    field(0, "R6 resumes");

    // single frame
    en_off();
    clr(3'b111, 1'b1, "R3 clear all");
    cap_mode = 2'd2; frame_mode = 1; cap_en = 1;
    field(1, "R8 before frame start");
    field(0, "R8 frame field1");
    field(1, "R8 frame field2");
    field(0, "R7 blocked f1");
    field(1, "R7 blocked f2");
    clr(3'b100, 1'b0, "R7 clear frame");
    field(0, "R7 frame field1");
    field(1, "R7 frame field2");

    // formats
    en_off();
    clr(3'b111, 1'b1, "R3 clear all");
    cap_mode = 2'd0; frame_mode = 0; sel_f1 = 1; fmt = 3'd0; cap_en = 1;
    field(0, "R9 embedded two strobes");
    fmt = 3'd3;
    field(0, "R9 invalid format");
    fmt = 3'd4;
    field(0, "R9 separate one strobe");

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule